// File: doc/BRIEF.md
# Dual-Style Host Register Port

This block is a synchronous slave port through which a host processor reads and writes an internal register file. All bus inputs are sampled on the rising edge of a host-supplied port clock. A mode strap picks the bus style, and both styles share the same pins. With the strap low, the port uses separate active-low read and write strobes. With the strap high, it uses one read/write direction line and an active-low data strobe. Each access is found by direct 8-bit addressing.

An access starts when chip select and a valid strobe are seen together. The ready output (acknowledge in the second style) then drops for a fixed internal latency and rises when the access has finished. For a read, the data is valid from the moment ready rises. Each access is 16 or 8 bits wide, chosen by a bit in an internal width-control register.

Addresses at or above the end of the register map are never acknowledged, so the host bus stalls until chip select is released. A serial-select strap disables the port whenever it is high.

Top module: `mpu_reg_port`

## Requirements
- R1: After reset, ready is high and the data output enable is low. Every register reads 0, except the width-control register at address 0x01, which reads 0x0001 (bit 0 = 1 means 16-bit accesses).
- R2: In separate-strobe style (busMode = 0), csN low with pinWrRw low and pinRdDs high performs a write of dataIn to the register at addr.
- R3: In separate-strobe style, csN low with pinRdDs low and pinWrRw high performs a read. dataOut holds the register value once ready is high again.
- R4: In single-strobe style (busMode = 1), csN low with pinRdDs (data strobe) low performs a read when pinWrRw = 1 and a write when pinWrRw = 0.
- R5: Ready falls after the rising edge that accepts an access. It stays low for exactly 2 port-clock cycles, then rises.
- R6: When bit 0 of the width-control register is 0, a write changes only bits 7:0 of the addressed register, and a read returns bits 7:0 with bits 15:8 zero.
- R7: An access to an address from 0xE8 to 0xFF keeps ready low for as long as csN stays low and changes no register. Ready returns high after csN is released.
- R8: While serialSel is high, no access is accepted: ready stays high, the output enable stays low, and no register changes.
- R9: No access starts when csN is high, when no strobe is active, or in separate-strobe style when both strobes are low at once.
- R10: After an access completes, ready stays high and no new access starts until csN has been sampled high.
- R11: dataOe is high only during an accepted mapped read, and it drops on the first rising edge that samples csN high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-supplied port clock |
| rstN | input | 1 | Active-low reset |
| serialSel | input | 1 | Serial-select strap, high disables the port |
| busMode | input | 1 | Bus style strap: 0 separate strobes, 1 single strobe |
| csN | input | 1 | Active-low chip select |
| pinWrRw | input | 1 | Write strobe (low active) or read/write direction (1 = read) |
| pinRdDs | input | 1 | Read strobe or data strobe, low active |
| addr | input | 8 | Register address |
| dataIn | input | 16 | Write data from the host |
| dataOut | output | 16 | Read data to the host |
| dataOe | output | 1 | Output enable for dataOut |
| readyOut | output | 1 | Ready (separate-strobe style) or acknowledge (single-strobe style), low while busy |

## Verification
The bench builds the block with its default parameters: 16-bit registers, 232 mapped locations, and a busy latency of 2 cycles. With these values, every mapped address can be swept in both bus styles. Each register is read after reset, written with an address-derived pattern in one style, and read back in the other. The same build also covers the switch to 8-bit width, stalls at the first and last unmapped addresses, the serial-select lockout, invalid strobe combinations, and a chip select held low after completion.

// File: rtl/mpu_port_pkg.sv
package mpu_port_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_BUSY = 2'd1,
    PS_DONE = 2'd2,
    PS_HANG = 2'd3
  } portState_t;

  typedef struct packed {
    logic capture;
    logic commitWr;
    logic commitRd;
  } portStrobes_t;

endpackage

// File: rtl/mpu_port_ctrl.sv
module mpu_port_ctrl
  import mpu_port_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MAP_LIMIT = 232,
  parameter int LATENCY   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              busMode,
  input  logic              csN,
  input  logic              pinWrRw,
  input  logic              pinRdDs,
  input  logic [ADDR_W-1:0] addr,
  output portStrobes_t      strobes,
  output logic              readyOut,
  output logic              dataOe
);

  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LATENCY - 1);

  portState_t state;
  logic [CNT_W-1:0] busyCnt;
  logic reqRead, reqWrite, request, mapped;

  // Read decode is identical in both styles; write decode depends on style
  always_comb begin
    reqRead  = !pinRdDs && pinWrRw;
    reqWrite = busMode ? (!pinRdDs && !pinWrRw) : (pinRdDs && !pinWrRw);
    request  = portEn && !csN && (reqRead || reqWrite);
    mapped   = (int'(addr) < MAP_LIMIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PS_IDLE;
      busyCnt <= '0;
      dataOe  <= 1'b0;
    end else begin
      unique case (state)
        PS_IDLE: if (request) begin
          busyCnt <= '0;
          if (mapped) begin
            state  <= PS_BUSY;
            dataOe <= reqRead;
          end else begin
            state <= PS_HANG;
          end
        end
        PS_BUSY: begin
          if (busyCnt == CNT_LAST) state <= PS_DONE;
          else busyCnt <= busyCnt + 1'b1;
          if (csN) dataOe <= 1'b0;
        end
        PS_DONE: if (csN) begin
          state  <= PS_IDLE;
          dataOe <= 1'b0;
        end
        PS_HANG: if (csN) state <= PS_IDLE;
        default: state <= PS_IDLE;
      endcase
    end
  end

  logic finishing;
  always_comb begin
    finishing        = (state == PS_BUSY) && (busyCnt == CNT_LAST);
    strobes.capture  = (state == PS_IDLE) && request && mapped;
    strobes.commitWr = finishing && !dataOe && !csN;
    strobes.commitRd = finishing && dataOe;
    readyOut         = (state == PS_IDLE) || (state == PS_DONE);
  end

endmodule

// File: rtl/mpu_port_regs.sv
module mpu_port_regs
  import mpu_port_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int MAP_LIMIT = 232,
  parameter int WIDTH_REG = 1,
  parameter int WIDE_BIT  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] regMem [MAP_LIMIT];
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] readQ;
  logic              wideMode;

  assign wideMode = regMem[WIDTH_REG][WIDE_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobes.capture) begin
      addrQ <= addr;
      dataQ <= dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MAP_LIMIT; i++) begin
        regMem[i] <= (i == WIDTH_REG) ? DATA_W'(1 << WIDE_BIT) : '0;
      end
    end else if (strobes.commitWr) begin
      if (wideMode) regMem[addrQ] <= dataQ;
      else          regMem[addrQ][HALF_W-1:0] <= dataQ[HALF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readQ <= '0;
    else if (strobes.commitRd) begin
      if (wideMode) readQ <= regMem[addrQ];
      else          readQ <= {{(DATA_W-HALF_W){1'b0}}, regMem[addrQ][HALF_W-1:0]};
    end
  end

  assign dataOut = readQ;

endmodule

// File: rtl/mpu_reg_port.sv
module mpu_reg_port
  import mpu_port_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int MAP_LIMIT = 232,
  parameter int LATENCY   = 2,
  parameter int WIDTH_REG = 1,
  parameter int WIDE_BIT  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialSel,
  input  logic              busMode,
  input  logic              csN,
  input  logic              pinWrRw,
  input  logic              pinRdDs,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              readyOut
);

  portStrobes_t strobes;

  mpu_port_ctrl #(
    .ADDR_W(ADDR_W), .MAP_LIMIT(MAP_LIMIT), .LATENCY(LATENCY)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .portEn(!serialSel), .busMode(busMode),
    .csN(csN), .pinWrRw(pinWrRw), .pinRdDs(pinRdDs), .addr(addr),
    .strobes(strobes), .readyOut(readyOut), .dataOe(dataOe)
  );

  mpu_port_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAP_LIMIT(MAP_LIMIT),
    .WIDTH_REG(WIDTH_REG), .WIDE_BIT(WIDE_BIT)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut)
  );

endmodule

// File: rtl/mpu_reg_port_chk.sv
module mpu_reg_port_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic serialSel,
  input logic readyOut,
  input logic dataOe
);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (readyOut && !dataOe)); // R1

  AST_MIN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyOut) |=> !readyOut); // R5

  AST_SERIAL_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (serialSel && readyOut) |=> readyOut); // R8

  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(readyOut) && !csN && $past(!csN)) |=> readyOut); // R10

  AST_OE_WITH_CS: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> $past(!csN)); // R11

endmodule

bind mpu_reg_port mpu_reg_port_chk uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .serialSel(serialSel),
  .readyOut(readyOut), .dataOe(dataOe)
);

// File: tb/mpu_reg_port_test.sv
module mpu_reg_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAPPED = 232;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serialSel = 1'b0;
  logic busMode = 1'b0;
  logic csN = 1'b1;
  logic pinWrRw = 1'b1;
  logic pinRdDs = 1'b1;
  logic [7:0] addr = '0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic dataOe;
  logic readyOut;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [MAPPED];

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_reg_port uut (
    .clk(clk), .rstN(rstN), .serialSel(serialSel), .busMode(busMode),
    .csN(csN), .pinWrRw(pinWrRw), .pinRdDs(pinRdDs), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .readyOut(readyOut)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doAccess(input logic mot, input logic wr, input logic [7:0] a,
                          input logic [15:0] d, output logic [15:0] rd,
                          output int busy, output logic hung, output logic oeSeen);
    @(negedge clk);
    busMode = mot; addr = a; dataIn = d;
    if (mot) begin pinWrRw = !wr; pinRdDs = 1'b0; end
    else begin pinWrRw = !wr; pinRdDs = wr; end
    csN = 1'b0;
    busy = 0;
    @(negedge clk);
    while (!readyOut && busy < 10) begin busy++; @(negedge clk); end
    hung = (busy >= 10);
    rd = dataOut; oeSeen = dataOe;
    csN = 1'b1; pinWrRw = 1'b1; pinRdDs = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [15:0] pat1(input int a);
    return {8'(a), ~8'(a)};
  endfunction
  function automatic logic [15:0] pat2(input int a);
    return {8'(a) ^ 8'hA5, 8'(a) + 8'h3C};
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int busy;
    logic hung, oe;

    repeat (3) @(negedge clk);
    chk(readyOut === 1'b1, "R1 ready in reset", 16'(readyOut), 16'd1);
    rstN = 1'b1;
    @(negedge clk);
    chk(readyOut === 1'b1 && dataOe === 1'b0, "R1 idle after reset", {readyOut, dataOe}, 16'b10);

    for (int a = 0; a < MAPPED; a++) model[a] = (a == 1) ? 16'h0001 : 16'h0000;

    // R1 / R3: reset contents via separate-strobe reads
    for (int a = 0; a < MAPPED; a++) begin
      doAccess(1'b0, 1'b0, 8'(a), 16'h0, rd, busy, hung, oe);
      chk(rd === model[a], "R1 R3 reset read", rd, model[a]);
      if (a == 0) begin
        chk(busy == 2, "R5 read busy cycles", 16'(busy), 16'd2);
        chk(oe === 1'b1, "R11 oe on read", 16'(oe), 16'd1);
        chk(dataOe === 1'b0, "R11 oe drops after cs", 16'(dataOe), 16'd0);
      end
    end

    // R2: separate-strobe writes
    for (int a = 0; a < MAPPED; a++) begin
      if (a == 1) continue;
      doAccess(1'b0, 1'b1, 8'(a), pat1(a), rd, busy, hung, oe);
      model[a] = pat1(a);
      chk(busy == 2, "R2 R5 write busy cycles", 16'(busy), 16'd2);
      if (a == 0) chk(oe === 1'b0, "R11 no oe on write", 16'(oe), 16'd0);
    end
    // R4: single-strobe reads
    for (int a = 0; a < MAPPED; a++) begin
      doAccess(1'b1, 1'b0, 8'(a), 16'h0, rd, busy, hung, oe);
      chk(rd === model[a], "R4 R2 single-strobe read", rd, model[a]);
    end
    // R4 writes, R3 reads
    for (int a = 0; a < MAPPED; a++) begin
      if (a == 1) continue;
      doAccess(1'b1, 1'b1, 8'(a), pat2(a), rd, busy, hung, oe);
      model[a] = pat2(a);
      chk(busy == 2, "R4 R5 single-strobe write busy", 16'(busy), 16'd2);
    end
    for (int a = 0; a < MAPPED; a++) begin
      doAccess(1'b0, 1'b0, 8'(a), 16'h0, rd, busy, hung, oe);
      chk(rd === model[a], "R3 R4 read back", rd, model[a]);
    end

    // R6: 8-bit mode
    doAccess(1'b0, 1'b1, 8'h01, 16'h0000, rd, busy, hung, oe);
    model[1] = 16'h0000;
    doAccess(1'b0, 1'b1, 8'h10, 16'hBEEF, rd, busy, hung, oe);
    model[16'h10] = {model[16'h10][15:8], 8'hEF};
    doAccess(1'b1, 1'b0, 8'h10, 16'h0, rd, busy, hung, oe);
    chk(rd === {8'h00, 8'hEF}, "R6 narrow read", rd, {8'h00, 8'hEF});
    doAccess(1'b1, 1'b1, 8'h01, 16'hFF01, rd, busy, hung, oe);
    model[1] = 16'h0001;
    doAccess(1'b0, 1'b0, 8'h01, 16'h0, rd, busy, hung, oe);
    chk(rd === 16'h0001, "R6 narrow write keeps high byte", rd, 16'h0001);
    doAccess(1'b0, 1'b0, 8'h10, 16'h0, rd, busy, hung, oe);
    chk(rd === model[16'h10], "R6 wide read after narrow write", rd, model[16'h10]);

    // R7: unmapped addresses stall
    doAccess(1'b0, 1'b1, 8'hE8, 16'h1234, rd, busy, hung, oe);
    chk(hung === 1'b1, "R7 stall at 0xE8", 16'(hung), 16'd1);
    chk(readyOut === 1'b1, "R7 ready back after cs release", 16'(readyOut), 16'd1);
    doAccess(1'b1, 1'b0, 8'hFF, 16'h0, rd, busy, hung, oe);
    chk(hung === 1'b1 && oe === 1'b0, "R7 stall at 0xFF", {hung, oe}, 16'b10);
    doAccess(1'b0, 1'b0, 8'hE7, 16'h0, rd, busy, hung, oe);
    chk(rd === model[231] && !hung, "R7 last mapped register intact", rd, model[231]);

    // R8: serial strap locks the port
    serialSel = 1'b1;
    @(negedge clk);
    busMode = 1'b0; addr = 8'h20; dataIn = 16'hCAFE; pinWrRw = 1'b0; pinRdDs = 1'b1; csN = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(readyOut === 1'b1 && dataOe === 1'b0, "R8 no access while serial", {readyOut, dataOe}, 16'b10);
    end
    csN = 1'b1; pinWrRw = 1'b1; serialSel = 1'b0;
    @(negedge clk);
    doAccess(1'b0, 1'b0, 8'h20, 16'h0, rd, busy, hung, oe);
    chk(rd === model[8'h20], "R8 register unchanged", rd, model[8'h20]);

    // R9: invalid strobe combinations
    @(negedge clk);
    busMode = 1'b0; addr = 8'h21; dataIn = 16'h7777; pinWrRw = 1'b0; pinRdDs = 1'b0; csN = 1'b0;
    repeat (3) @(negedge clk);
    chk(readyOut === 1'b1, "R9 both strobes low ignored", 16'(readyOut), 16'd1);
    csN = 1'b1; pinRdDs = 1'b1;
    repeat (3) @(negedge clk);
    chk(readyOut === 1'b1, "R9 strobe without cs ignored", 16'(readyOut), 16'd1);
    busMode = 1'b1; pinWrRw = 1'b0; pinRdDs = 1'b1; csN = 1'b0;
    repeat (3) @(negedge clk);
    chk(readyOut === 1'b1, "R9 cs without data strobe ignored", 16'(readyOut), 16'd1);
    csN = 1'b1; pinWrRw = 1'b1;
    @(negedge clk);
    doAccess(1'b0, 1'b0, 8'h21, 16'h0, rd, busy, hung, oe);
    chk(rd === model[8'h21], "R9 register unchanged", rd, model[8'h21]);

    // R10: cs held low after completion
    @(negedge clk);
    busMode = 1'b0; addr = 8'h30; dataIn = 16'h4242; pinWrRw = 1'b0; pinRdDs = 1'b1; csN = 1'b0;
    repeat (3) @(negedge clk);
    chk(readyOut === 1'b1, "R10 access completed", 16'(readyOut), 16'd1);
    dataIn = 16'h9999;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(readyOut === 1'b1, "R10 no second access", 16'(readyOut), 16'd1);
    end
    csN = 1'b1; pinWrRw = 1'b1;
    @(negedge clk);
    model[8'h30] = 16'h4242;
    doAccess(1'b1, 1'b0, 8'h30, 16'h0, rd, busy, hung, oe);
    chk(rd === 16'h4242, "R10 first data kept", rd, 16'h4242);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule